// File: doc/BRIEF.md
# Serial Flash Auto-Increment Word Program Responder

This block sits on the device side of a four-wire serial bus and answers the host the way a serial flash does while it programs in auto-increment word mode. The serial inputs are sampled in the system clock domain. The block decodes a small command set and keeps three pieces of state: the write-enable latch, the auto-increment mode flag and an internal address pointer. Each accepted word produces two byte write strobes on a plain memory port. The block then stays busy for a programmable number of system clocks.

A word sequence opens with a frame that carries a 24-bit address and two data bytes. Later frames carry only the two data bytes, and the pointer steps forward by two for each accepted word. The sequence ends in one of two ways: a write-disable command, or the pointer running past the top of the unprotected range. The pointer never wraps. The serial output either shifts out a status byte or, when selected for it, drives a live ready/busy level for as long as chip-select is low during the sequence.

Top module: `spi_autoinc_prog`

## Requirements
- R1: Opcode 05h returns a status byte, MSB first, starting with the first clock after the 8 opcode bits. The byte repeats for as long as clocks continue. Bit 0 is busy, bit 1 is the write-enable latch, bit 6 is the auto-increment flag, and all other bits are 0. Everything is clear after reset.
- R2: A frame of exactly 8 bits with opcode 06h sets the write-enable latch. A frame of exactly 8 bits with opcode 04h clears both the latch and the auto-increment flag, even while busy.
- R3: A word-program frame (opcode ADh) is ignored in any of three cases: the write-enable latch is clear, the block is busy, or the odd byte address of the word lies above `unprot_top`.
- R4: Outside auto-increment mode, an accepted ADh frame is exactly 48 bits long: the opcode, then a 24-bit address MSB first, then two data bytes. Address bit 0 is forced to 0. The first byte is written to the even address and the second to the odd address, as two consecutive `mem_we` cycles with the even one first. Both strobes come after chip-select rises.
- R5: Inside auto-increment mode, an ADh frame is exactly 24 bits long: the opcode and two data bytes. It writes at the pointer, and the pointer advances by 2 for each accepted word.
- R6: While auto-increment mode is active, only opcodes ADh, 05h and 04h have any effect. Opcodes 06h, 70h and 80h are ignored.
- R7: Once an accepted word's chip-select rise has been seen, the block stays busy for BUSY_CYC system clocks. Its write strobes fall inside that interval.
- R8: Opcode 70h enables the ready/busy output and opcode 80h disables it. Each is accepted only outside auto-increment mode. When the output is enabled and the mode is active, a low chip-select drives SO with 1 when ready and 0 when busy.
- R9: `miso_oe` is 0 whenever chip-select is high and whenever the block has nothing to drive.
- R10: After an accepted word, if the next word's odd address would exceed `unprot_top`, the block clears both the auto-increment flag and the write-enable latch.
- R11: A frame whose bit count differs from the count its command needs changes no state and issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| unprot_top | input | ADDR_W | Highest unprotected byte address |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso; 0 means high impedance |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |

## Verification
Two things can coincide in one cycle: a write-disable that ends the mode, and the busy interval with its two write strobes from the word just before it. The bench issues a word and follows it at once with 04h while the countdown is still running. It then judges the result by the status byte, which must show busy alone, and by both bytes of the word landing in the bench memory model. A second overlap arises at the top of the range. There, the mode exit and the busy start come from the same deselect. The bench sweeps every word start in a 32-byte window and computes each byte and the status bits arithmetically.

// File: rtl/spi_autoinc_pkg.sv
package spi_autoinc_pkg;
  localparam logic [7:0] OPC_WREN    = 8'h06;
  localparam logic [7:0] OPC_WRDI    = 8'h04;
  localparam logic [7:0] OPC_RDSR    = 8'h05;
  localparam logic [7:0] OPC_WORD    = 8'hAD;
  localparam logic [7:0] OPC_RBY_ON  = 8'h70;
  localparam logic [7:0] OPC_RBY_OFF = 8'h80;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_MODE = 6;

  function automatic logic [7:0] make_status(input logic busy, input logic wel,
                                             input logic mode);
    logic [7:0] s;
    s = 8'h00;
    s[ST_BUSY] = busy;
    s[ST_WEL]  = wel;
    s[ST_MODE] = mode;
    return s;
  endfunction
endpackage

// File: rtl/spi_autoinc_frontend.sv
module spi_autoinc_frontend #(
  parameter int SYNC  = 2,
  parameter int SH_W  = 40,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             mosi,
  output logic             sel_o,
  output logic             start_o,
  output logic             end_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [2:0]       bpos_o,
  output logic [SH_W-1:0]  sh_o
);
  logic [SYNC-1:0] cs_p, sck_p, mo_p;
  logic cs_s, sck_s, mo_s, cs_d, sck_d, rise;

  assign cs_s  = cs_p[SYNC-1];
  assign sck_s = sck_p[SYNC-1];
  assign mo_s  = mo_p[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= '1;
      sck_p <= '0;
      mo_p  <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_p  <= {cs_p[SYNC-2:0], cs_n};
      sck_p <= {sck_p[SYNC-2:0], sck};
      mo_p  <= {mo_p[SYNC-2:0], mosi};
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign sel_o   = !cs_s;
  assign start_o = !cs_s && cs_d;
  assign end_o   = cs_s && !cs_d;
  assign rise    = !cs_s && sck_s && !sck_d;
  assign fall_o  = !cs_s && !sck_s && sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      bpos_o <= '0;
      sh_o   <= '0;
    end else if (start_o) begin
      cnt_o  <= '0;
      bpos_o <= '0;
    end else if (rise) begin
      if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
      bpos_o <= bpos_o + 3'd1;
      sh_o   <= {sh_o[SH_W-2:0], mo_s};
    end
  end

  assert_count_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_s) |=> (cnt_o == '0));
endmodule

// File: rtl/spi_autoinc_busy.sv
module spi_autoinc_busy #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_o
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= W'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_o);
endmodule

// File: rtl/spi_autoinc_prog.sv
module spi_autoinc_prog
  import spi_autoinc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BUSY_CYC = 64,
  parameter int SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic [ADDR_W-1:0] unprot_top,
  output logic              miso,
  output logic              miso_oe,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int LEN_CMD   = 8;
  localparam int LEN_CONT  = 8 + 16;
  localparam int LEN_FIRST = 8 + ADDR_W + 16;
  localparam int SH_W      = LEN_FIRST - 8;
  localparam int CNT_W     = $clog2(LEN_FIRST + 2);

  logic             sel, start_p, end_p, fall_p, busy;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bpos;
  logic [SH_W-1:0]  sh;

  spi_autoinc_frontend #(.SYNC(SYNC), .SH_W(SH_W), .CNT_W(CNT_W)) fe_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .sel_o(sel), .start_o(start_p), .end_o(end_p), .fall_o(fall_p),
    .cnt_o(cnt), .bpos_o(bpos), .sh_o(sh));

  logic [7:0]        op_q, tx_q, d0_q, d1_q;
  logic              wel_q, mode_q, rby_q;
  logic [ADDR_W-1:0] ptr_q, wa_q;
  logic [1:0]        ph_q;

  // opcode is visible in the shifter while exactly 8 bits have arrived
  always_ff @(posedge clk) begin
    if (rst || start_p)               op_q <= 8'h00;
    else if (cnt == CNT_W'(LEN_CMD))  op_q <= sh[7:0];
  end

  logic              is_cmd, first_ok, cont_ok, word_ok, last_word;
  logic [ADDR_W-1:0] addr_in, tgt;
  logic [ADDR_W:0]   odd_ext, top_ext;

  assign is_cmd   = (cnt == CNT_W'(LEN_CMD));
  assign addr_in  = sh[ADDR_W+15:16];
  assign first_ok = !mode_q && (cnt == CNT_W'(LEN_FIRST));
  assign cont_ok  =  mode_q && (cnt == CNT_W'(LEN_CONT));
  assign tgt      = mode_q ? ptr_q : {addr_in[ADDR_W-1:1], 1'b0};
  assign odd_ext  = {1'b0, tgt | ADDR_W'(1)};
  assign top_ext  = {1'b0, unprot_top};
  assign word_ok  = end_p && (op_q == OPC_WORD) && (first_ok || cont_ok) &&
                    wel_q && !busy && (odd_ext <= top_ext);
  assign last_word = (odd_ext + (ADDR_W+1)'(2)) > top_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      mode_q <= 1'b0;
      rby_q  <= 1'b0;
      ptr_q  <= '0;
    end else if (end_p) begin
      case (op_q)
        OPC_WREN:    if (is_cmd && !mode_q) wel_q <= 1'b1;
        OPC_WRDI:    if (is_cmd) begin wel_q <= 1'b0; mode_q <= 1'b0; end
        OPC_RBY_ON:  if (is_cmd && !mode_q) rby_q <= 1'b1;
        OPC_RBY_OFF: if (is_cmd && !mode_q) rby_q <= 1'b0;
        OPC_WORD:
          if (word_ok) begin
            ptr_q <= tgt + ADDR_W'(2);
            if (last_word) begin
              wel_q  <= 1'b0;
              mode_q <= 1'b0;
            end else begin
              mode_q <= 1'b1;
            end
          end
        default: ;
      endcase
    end
  end

  spi_autoinc_busy #(.CYC(BUSY_CYC)) busy_i (
    .clk(clk), .rst(rst), .start(word_ok), .busy_o(busy));

  // two-phase byte write sequencer: even byte, then odd byte
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= 2'd0;
      wa_q      <= '0;
      d0_q      <= 8'h00;
      d1_q      <= 8'h00;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 8'h00;
    end else begin
      mem_we <= 1'b0;
      if (word_ok) begin
        ph_q <= 2'd1;
        wa_q <= tgt;
        d0_q <= sh[15:8];
        d1_q <= sh[7:0];
      end else if (ph_q == 2'd1) begin
        mem_we    <= 1'b1;
        mem_addr  <= wa_q;
        mem_wdata <= d0_q;
        ph_q      <= 2'd2;
      end else if (ph_q == 2'd2) begin
        mem_we    <= 1'b1;
        mem_addr  <= wa_q | ADDR_W'(1);
        mem_wdata <= d1_q;
        ph_q      <= 2'd0;
      end
    end
  end

  // serial output: status shifter or live ready/busy level
  logic rby_live, rd_act;
  assign rby_live = rby_q && mode_q;
  assign rd_act   = (op_q == OPC_RDSR);

  always_ff @(posedge clk) begin
    if (rst || start_p) tx_q <= 8'h00;
    else if (fall_p && rd_act) begin
      if (bpos == 3'd0) tx_q <= make_status(busy, wel_q, mode_q);
      else              tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= sel && (rby_live || rd_act);
      miso    <= rby_live ? !busy : tx_q[7];
    end
  end

  assert_mode_needs_wel_R2: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> wel_q);
  assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  assert_write_follows_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> mem_we);
  assert_even_first_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !$past(mem_we)) |-> !mem_addr[0]);
  assert_write_unprotected_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, mem_addr} <= top_ext));
  assert_hiz_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(sel) |-> !miso_oe);
endmodule

// File: tb/spi_autoinc_prog_tb.sv
module spi_autoinc_prog_tb_top;
  localparam int BUSY = 500;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [23:0] unprot_top = 24'h00001F;
  logic miso, miso_oe, mem_we;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata;

  always #10 clk = ~clk;

  spi_autoinc_prog #(.ADDR_W(24), .BUSY_CYC(BUSY), .SYNC(2)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .unprot_top(unprot_top), .miso(miso), .miso_oe(miso_oe),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  logic [7:0] mem [0:255];
  int wcount = 0, total = 0, bad = 0;
  logic done = 1'b0;

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr[7:0]] <= mem_wdata;
    wcount <= wcount + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [47:0] v, input int n, output logic [7:0] rd);
    rd = 8'h00;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      repeat (HALF) @(negedge clk);
      rd = {rd[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    xfer({40'h0, op}, 8, d);
  endtask

  task automatic status(output logic [7:0] s);
    xfer({32'h0, 8'h05, 8'h00}, 16, s);
  endtask

  task automatic word_first(input logic [23:0] a, input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] d;
    xfer({8'hAD, a, b0, b1}, 48, d);
  endtask

  task automatic word_next(input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] d;
    xfer({24'h0, 8'hAD, b0, b1}, 24, d);
  endtask

  task automatic wait_idle();
    repeat (BUSY + 40) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int wc;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    chk("R9 reset oe", 32'(miso_oe), 0);
    status(s); chk("R1 reset status", 32'(s), 32'h00);

    word_first(24'h10, 8'h11, 8'h22); wait_idle();
    chk("R3 no wel write", wcount, 0);
    status(s); chk("R3 no wel status", 32'(s), 32'h00);

    cmd(8'h06); status(s); chk("R2 wren", 32'(s), 32'h02);

    // R4 first word, odd address forced even
    word_first(24'h11, 8'hA1, 8'hB2);
    status(s); chk("R7 busy in status", 32'(s), 32'h43);
    wait_idle();
    chk("R4 even byte", 32'(mem[8'h10]), 32'hA1);
    chk("R4 odd byte", 32'(mem[8'h11]), 32'hB2);
    chk("R4 write count", wcount, 2);
    status(s); chk("R1 mode status", 32'(s), 32'h42);

    // R6 70h ignored in mode: status read must still shift status
    cmd(8'h70); status(s); chk("R6 70h ignored", 32'(s), 32'h42);

    // R11 short frame
    xfer({32'h0, 8'hAD, 8'hC3}, 16, s); wait_idle();
    chk("R11 short frame", wcount, 2);

    // R5 continuation; R3 word during busy ignored
    word_next(8'hC3, 8'hD4);
    word_next(8'h99, 8'h98);
    wait_idle();
    chk("R5 cont even", 32'(mem[8'h12]), 32'hC3);
    chk("R5 cont odd", 32'(mem[8'h13]), 32'hD4);
    chk("R3 busy ignored", wcount, 4);
    word_next(8'hE5, 8'hF6); wait_idle();
    chk("R5 pointer held", 32'(mem[8'h14]), 32'hE5);
    chk("R5 pointer held odd", 32'(mem[8'h15]), 32'hF6);

    // R10 run to the top of the unprotected range
    for (int a = 16'h16; a <= 16'h1E; a += 2) begin
      word_next(pat(a, 1), pat(a + 1, 1)); wait_idle();
      chk("R5 sweep even", 32'(mem[a[7:0]]), 32'(pat(a, 1)));
      chk("R5 sweep odd", 32'(mem[8'(a + 1)]), 32'(pat(a + 1, 1)));
      status(s);
      chk("R10 exit at top", 32'(s), (a == 16'h1E) ? 32'h00 : 32'h42);
    end
    wc = wcount;
    word_next(8'h55, 8'h66); wait_idle();
    chk("R10 no wrap", wcount, wc);

    // R2 write-disable overlapping busy interval
    cmd(8'h06);
    word_first(24'h0, 8'h3C, 8'h4D);
    cmd(8'h04);
    status(s); chk("R2 wrdi during busy", 32'(s), 32'h01);
    wait_idle();
    chk("R2 overlap even", 32'(mem[0]), 32'h3C);
    chk("R2 overlap odd", 32'(mem[1]), 32'h4D);
    status(s); chk("R2 wrdi idle", 32'(s), 32'h00);

    // R3 protected target
    wc = wcount;
    cmd(8'h06); word_first(24'h20, 8'h01, 8'h02); wait_idle();
    chk("R3 protected", wcount, wc);
    status(s); chk("R3 protected status", 32'(s), 32'h02);

    // R8 ready/busy on SO
    cmd(8'h70);
    word_first(24'h2, 8'h71, 8'h72);
    @(negedge clk); cs_n = 1'b0; repeat (8) @(negedge clk);
    chk("R8 busy oe", 32'(miso_oe), 1);
    chk("R8 busy level", 32'(miso), 0);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    chk("R9 deselect hiz", 32'(miso_oe), 0);
    wait_idle();
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk("R8 ready level", 32'(miso), 1);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    cmd(8'h80);
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk("R8 80h ignored in mode", 32'(miso_oe), 1);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    cmd(8'h04); cmd(8'h80); cmd(8'h06);
    word_first(24'h8, 8'h81, 8'h82);
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk("R8 80h disables", 32'(miso_oe), 0);
    cs_n = 1'b1; wait_idle();
    cmd(8'h04);

    // R4 sweep over every word start, odd starts forced even
    for (int k = 0; k < 32; k++) begin
      cmd(8'h06);
      word_first(24'(k), pat(k, 7), pat(k, 9));
      wait_idle();
      chk("R4 sweep even", 32'(mem[8'(k & 30)]), 32'(pat(k, 7)));
      chk("R4 sweep odd", 32'(mem[8'((k & 30) | 1)]), 32'(pat(k, 9)));
      cmd(8'h04);
    end
    status(s); chk("R1 final status", 32'(s), 32'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule